// File: doc/BRIEF.md
# Mode-Dependent Effective Address Generator

This block forms the operand address of an instruction from three contributions: a base register value, an index register value and a displacement field. The caller also passes the register field numbers for base and index, because field 0 means "no register" and then adds nothing. The address size depends on the current addressing mode, which may be 24, 31 or 64 bits. Base and index are unsigned, and only their low bits inside the active size are used. The displacement is either a short unsigned 12-bit field or a long signed 20-bit field. A long displacement that is negative moves the address downwards.

The sum is cut to the active width, so it wraps silently at the top and at the bottom of the address space. The result is then zero-extended to 64 bits. Ordinary operand addresses, which may be virtual, never raise an exception here. The block only forms addresses; a later stage accesses storage. Table-entry fetches made with real or absolute addresses are different. For these, a build parameter chooses between two behaviours when the address goes out of range: wrap silently, or raise an addressing exception while still presenting the wrapped address. The result appears one clock after the request.

Top module: `ea_gen`

## Requirements
- R1: With `addrMode` = 2'b00 (24-bit), the result is (base + index + displacement) modulo 2^24, and bits 63..24 of `effAddr` are zero.
- R2: With `addrMode` = 2'b01 (31-bit), the result is the sum modulo 2^31, and bits 63..31 of `effAddr` are zero.
- R3: With `addrMode` = 2'b10 or 2'b11 (64-bit), the result is the sum modulo 2^64, and the carry out of bit 63 is dropped.
- R4: When `dispLong` = 0, only `dispRaw[11:0]` is used, as an unsigned value from 0 to 4095. Bits 19..12 have no effect.
- R5: When `dispLong` = 1, all 20 bits of `dispRaw` are a two's-complement value, sign-extended before the add. Base 0 with displacement -1 gives the all-ones address of the active mode.
- R6: A `baseReg` or `indexReg` field equal to 0 contributes zero, whatever value appears on `baseVal` or `indexVal`.
- R7: Base and index bits at or above the active address size have no effect on the result.
- R8: When `realTable` = 0, `addrExc` stays 0 even if the sum goes out of range.
- R9: When `realTable` = 1 and the parameter `TRAP_TABLE_OVF` = 1, a sum outside 0 .. max-address sets `addrExc` = 1 together with the wrapped address. An in-range sum gives `addrExc` = 0.
- R10: Each cycle with `inValid` high produces `outValid` high exactly one clock later, carrying that request's result. A cycle without `inValid` leaves `outValid` low one clock later.
- R11: A synchronous reset clears `outValid` and `addrExc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| inValid | input | 1 | request strobe |
| baseReg | input | 4 | base register field number; 0 means none |
| baseVal | input | 64 | base register contents |
| indexReg | input | 4 | index register field number; 0 means none |
| indexVal | input | 64 | index register contents |
| dispRaw | input | 20 | displacement field; low 12 bits used in short format |
| dispLong | input | 1 | 1 selects the signed 20-bit format |
| addrMode | input | 2 | 00 = 24-bit, 01 = 31-bit, 1x = 64-bit |
| realTable | input | 1 | table-entry fetch made with a real or absolute address |
| outValid | output | 1 | result valid, one clock after inValid |
| effAddr | output | 64 | effective address, zero-extended |
| addrExc | output | 1 | addressing exception on an out-of-range table fetch |

## Verification
The bench aims at the wrap points of each mode.

- Base 0 with displacement -1 in every mode must give that mode's all-ones value. A design that sign-extends wrongly or masks wrongly would return a 64-bit all-ones value, or a negative-looking value, in the narrow modes.
- An all-ones index plus a positive short displacement in 64-bit mode must wrap to a small address. A design that keeps the carry would corrupt the result.
- Large junk bits above 24 or 31 bits, and register fields of 0 with nonzero contents, must not leak into the sum.
- Exceptions are checked both ways. Overflow and underflow on a table fetch must set the flag, while the same sum on a normal fetch must not. A design that traps virtual addresses, or misses the underflow of a negative displacement, would show up here.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [1:0] {
    MODE_24  = 2'b00,
    MODE_31  = 2'b01,
    MODE_64  = 2'b10,
    MODE_64X = 2'b11
  } addrMode_e;

  typedef struct packed {
    logic capture;
    logic raiseExc;
  } ctlStrobes_t;

endpackage

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SHORT_W = 12,
  parameter int LONG_W  = 20,
  parameter int FIELD_W = 4,
  parameter int NARROW_A = 24,
  parameter int NARROW_B = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FIELD_W-1:0]  baseReg,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [FIELD_W-1:0]  indexReg,
  input  logic [ADDR_W-1:0]   indexVal,
  input  logic [LONG_W-1:0]   dispRaw,
  input  logic                dispLong,
  input  logic [1:0]          addrMode,
  input  ctlStrobes_t         strobes,
  output logic                overflow,
  output logic [ADDR_W-1:0]   effAddr,
  output logic                addrExc
);

  localparam int SUM_W = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] MASK_A = {ADDR_W{1'b1}} >> (ADDR_W - NARROW_A);
  localparam logic [ADDR_W-1:0] MASK_B = {ADDR_W{1'b1}} >> (ADDR_W - NARROW_B);
  localparam logic [ADDR_W-1:0] MASK_F = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] activeMask;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [SUM_W-1:0]  dispExt;
  logic [SUM_W-1:0]  wideSum;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    unique case (addrMode_e'(addrMode))
      MODE_24: activeMask = MASK_A;
      MODE_31: activeMask = MASK_B;
      default: activeMask = MASK_F;
    endcase
  end

  always_comb begin
    baseTerm  = (baseReg  == '0) ? '0 : (baseVal  & activeMask);
    indexTerm = (indexReg == '0) ? '0 : (indexVal & activeMask);
  end

  always_comb begin
    if (dispLong)
      dispExt = {{(SUM_W-LONG_W){dispRaw[LONG_W-1]}}, dispRaw};
    else
      dispExt = {{(SUM_W-SHORT_W){1'b0}}, dispRaw[SHORT_W-1:0]};
  end

  always_comb begin
    wideSum  = {2'b00, baseTerm} + {2'b00, indexTerm} + dispExt;
    overflow = wideSum[SUM_W-1] | (wideSum[ADDR_W:0] > {1'b0, activeMask});
    nextAddr = wideSum[ADDR_W-1:0] & activeMask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      effAddr <= '0;
      addrExc <= 1'b0;
    end else if (strobes.capture) begin
      effAddr <= nextAddr;
      addrExc <= strobes.raiseExc;
    end
  end

endmodule

// File: rtl/ea_control.sv
module ea_control
  import ea_gen_pkg::*;
#(
  parameter bit TRAP_TABLE_OVF = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        realTable,
  input  logic        overflow,
  output ctlStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.capture  = inValid;
    strobes.raiseExc = inValid & realTable & overflow & TRAP_TABLE_OVF;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SHORT_W = 12,
  parameter int LONG_W  = 20,
  parameter int FIELD_W = 4,
  parameter bit TRAP_TABLE_OVF = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [FIELD_W-1:0] baseReg,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [FIELD_W-1:0] indexReg,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [LONG_W-1:0]  dispRaw,
  input  logic               dispLong,
  input  logic [1:0]         addrMode,
  input  logic               realTable,
  output logic               outValid,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               addrExc
);

  ctlStrobes_t strobes;
  logic        overflow;

  ea_control #(.TRAP_TABLE_OVF(TRAP_TABLE_OVF)) u_ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .realTable(realTable),
    .overflow(overflow), .strobes(strobes), .outValid(outValid)
  );

  ea_datapath #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .FIELD_W(FIELD_W)
  ) u_dp (
    .clk(clk), .rst(rst), .baseReg(baseReg), .baseVal(baseVal),
    .indexReg(indexReg), .indexVal(indexVal), .dispRaw(dispRaw),
    .dispLong(dispLong), .addrMode(addrMode), .strobes(strobes),
    .overflow(overflow), .effAddr(effAddr), .addrExc(addrExc)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        addrMode,
  input logic              realTable,
  input logic              outValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic              addrExc
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R1
  narrow24_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && addrMode == 2'b00) |=> (effAddr[ADDR_W-1:24] == '0));

  // R2
  narrow31_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && addrMode == 2'b01) |=> (effAddr[ADDR_W-1:31] == '0));

  // R8
  virtual_no_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !realTable) |=> !addrExc);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !addrExc));

endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .addrMode(addrMode),
  .realTable(realTable), .outValid(outValid), .effAddr(effAddr),
  .addrExc(addrExc)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  baseReg = '0;
  logic [63:0] baseVal = '0;
  logic [3:0]  indexReg = '0;
  logic [63:0] indexVal = '0;
  logic [19:0] dispRaw = '0;
  logic        dispLong = 1'b0;
  logic [1:0]  addrMode = '0;
  logic        realTable = 1'b0;
  logic        outValid;
  logic [63:0] effAddr;
  logic        addrExc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] addr;
    logic        exc;
    string       req;
  } expItem_t;
  expItem_t sbq[$];

  always #10 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst(rst), .inValid(inValid), .baseReg(baseReg),
    .baseVal(baseVal), .indexReg(indexReg), .indexVal(indexVal),
    .dispRaw(dispRaw), .dispLong(dispLong), .addrMode(addrMode),
    .realTable(realTable), .outValid(outValid), .effAddr(effAddr),
    .addrExc(addrExc)
  );

  function automatic expItem_t model(input logic [1:0] m, input logic [3:0] br,
      input logic [63:0] bv, input logic [3:0] ir, input logic [63:0] iv,
      input logic [19:0] d, input logic lg, input logic rt, input string req);
    expItem_t e;
    logic [63:0] mk;
    logic signed [66:0] s;
    mk = (m == 2'b00) ? 64'h0000_0000_00FF_FFFF :
         (m == 2'b01) ? 64'h0000_0000_7FFF_FFFF : '1;
    s = 0;
    if (br != 0) s = s + $signed({3'b0, bv & mk});
    if (ir != 0) s = s + $signed({3'b0, iv & mk});
    if (lg) s = s + $signed({{47{d[19]}}, d});
    else    s = s + $signed({55'b0, d[11:0]});
    e.addr = s[63:0] & mk;
    e.exc  = rt && ((s < 0) || (s > $signed({3'b0, mk})));
    e.req  = req;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [3:0] br, input logic [63:0] bv,
      input logic [3:0] ir, input logic [63:0] iv, input logic [19:0] d,
      input logic lg, input logic rt, input string req);
    @(negedge clk);
    addrMode = m; baseReg = br; baseVal = bv; indexReg = ir; indexVal = iv;
    dispRaw = d; dispLong = lg; realTable = rt; inValid = 1'b1;
    sbq.push_back(model(m, br, bv, ir, iv, d, lg, rt, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R10", "unexpected outValid", 64'd1, 64'd0);
      end else begin
        expItem_t e;
        e = sbq.pop_front();
        check(effAddr === e.addr, e.req, "address", effAddr, e.addr);
        check(addrExc === e.exc, e.req, "exception", {63'b0, addrExc}, {63'b0, e.exc});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(outValid === 1'b0, "R11", "outValid after reset", {63'b0, outValid}, 64'd0);
    check(addrExc === 1'b0, "R11", "addrExc after reset", {63'b0, addrExc}, 64'd0);
    rst = 1'b0;

    // R5 / R1 / R2 / R3: base 0 with displacement -1 in each mode
    drive(2'b00, 4'd3, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b0, "R1");
    drive(2'b01, 4'd3, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b0, "R2");
    drive(2'b10, 4'd3, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b0, "R5");
    drive(2'b11, 4'd3, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b0, "R3");
    // R3 all-ones index plus positive displacement wraps to 15
    drive(2'b10, 4'd0, 64'd0, 4'd7, '1, 20'h00010, 1'b0, 1'b0, "R3");
    // R4 short field: high bits ignored, adds 4095
    drive(2'b10, 4'd2, 64'h1000, 4'd0, 64'd0, 20'hFFFFF, 1'b0, 1'b0, "R4");
    // R5 negative long displacement steps back
    drive(2'b01, 4'd2, 64'h0000_1000, 4'd0, 64'd0, 20'hFFF00, 1'b1, 1'b0, "R5");
    // R6 field 0 ignores register contents
    drive(2'b10, 4'd0, 64'hDEAD_BEEF, 4'd0, 64'h1234, 20'h00005, 1'b0, 1'b0, "R6");
    // R7 high bits above the active size ignored
    drive(2'b00, 4'd1, 64'hFFFF_FFFF_0100_0000, 4'd4, 64'h5, 20'h0, 1'b0, 1'b0, "R7");
    drive(2'b01, 4'd1, 64'hF000_0000_8000_0010, 4'd0, 64'd0, 20'h1, 1'b0, 1'b0, "R7");
    // R8 overflow on a virtual address: no exception
    drive(2'b01, 4'd1, 64'h7FFF_FFFF, 4'd0, 64'd0, 20'h1, 1'b0, 1'b0, "R8");
    drive(2'b00, 4'd0, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b0, "R8");
    // R9 table fetch: overflow, underflow, in range
    drive(2'b01, 4'd1, 64'h7FFF_FFFF, 4'd0, 64'd0, 20'h1, 1'b0, 1'b1, "R9");
    drive(2'b00, 4'd0, 64'd0, 4'd0, 64'd0, 20'hFFFFF, 1'b1, 1'b1, "R9");
    drive(2'b10, 4'd1, '1, 4'd2, 64'd1, 20'h0, 1'b0, 1'b1, "R9");
    drive(2'b00, 4'd1, 64'h100, 4'd2, 64'h20, 20'h3, 1'b0, 1'b1, "R9");
    idle(1);
    // R10 idle cycle leaves outValid low
    idle(1);
    check(outValid === 1'b0, "R10", "outValid idle", {63'b0, outValid}, 64'd0);
    drive(2'b10, 4'd1, 64'h40, 4'd1, 64'h2, 20'h0, 1'b0, 1'b0, "R10");
    idle(1);
    check(outValid === 1'b1, "R10", "outValid latency", {63'b0, outValid}, 64'd1);
    // R11 reset after an exception
    drive(2'b01, 4'd1, 64'h7FFF_FFFF, 4'd0, 64'd0, 20'h1, 1'b0, 1'b1, "R9");
    idle(1);
    check(addrExc === 1'b1, "R9", "exception held", {63'b0, addrExc}, 64'd1);
    rst = 1'b1;
    sbq.delete();
    @(negedge clk);
    check(outValid === 1'b0, "R11", "outValid cleared", {63'b0, outValid}, 64'd0);
    check(addrExc === 1'b0, "R11", "addrExc cleared", {63'b0, addrExc}, 64'd0);
    rst = 1'b0;
    idle(2);
    check(sbq.size() == 0, "R10", "scoreboard drained", 64'(sbq.size()), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule